// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a serial two-wire (I2C) target, running at standard-mode rates, that holds a small bank of 8-bit configuration bytes for a clock-generation subsystem. The host addresses it with write byte 0xD2 or read byte 0xD3. A write sends two framing bytes, a command code and then a byte count. The slave acknowledges both and then discards them. Every data byte after those is stored, starting at byte 0 and moving upward one byte at a time. A read returns the number of implemented bytes first and then the bytes themselves, starting at byte 0.

SCL and SDA are oversampled in the system clock domain. Each line passes through a synchronizer chain and an edge detector. START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high. A single enumerated state machine sequences each transfer. Its states are ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_CNT, ST_CNT_ACK, ST_WR, ST_WR_ACK, ST_TX and ST_TX_ACK. The transitions are:
- START moves to ST_ADDR from any state.
- STOP moves to ST_IDLE from any state.
- In ST_ADDR, a matching address moves to ST_ADDR_ACK and a mismatch returns to ST_IDLE.
- ST_ADDR_ACK moves to ST_CMD on a write or to ST_TX on a read.
- The write path runs CMD, CMD_ACK, CNT, CNT_ACK, WR, WR_ACK, then back to WR.
- The read path runs TX, TX_ACK, then back to TX, and a host NACK returns it to ST_IDLE.

Every state change other than START and STOP happens on an SCL falling edge.

A frequency-select output is driven from one of two sources. At the first system clock edge after reset is released, the 5 strap inputs are captured and frozen. Configuration byte 0 bit 3 chooses between those captured straps and a value formed from byte 0 itself.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, byte 0 is 0x00, bytes 1 to 5 are 0xFF, and byte 6 (the last, reserved byte) is 0x06. Byte k is bits 8k+7:8k of cfg_regs.
- R2: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read). It does not acknowledge any other address, and it acknowledges nothing else until the next START.
- R3: The command byte and the count byte of a write are acknowledged, and neither changes any register.
- R4: Data bytes of a write go to byte 0, then byte 1, and so on. A STOP after any whole byte keeps the bytes already received. Every new write starts again at byte 0.
- R5: Data bytes beyond the last implemented byte are acknowledged and discarded.
- R6: A read returns the count 7 first and then bytes 0 to 6 in order. A host NACK ends the read.
- R7: When byte 0 bit 3 is 1, fs_sel equals {byte0[2], byte0[7:4]}. When it is 0, fs_sel equals the captured strap value.
- R8: The straps are captured at the first clock edge after reset release. Later changes on strap_fs have no effect.
- R9: sda_oe changes only while SCL is low.
- R10: At most one configuration byte changes in any system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as sensed |
| sda_i | input | 1 | Serial data line as sensed |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| strap_fs | input | 5 | Board-strapped frequency select, captured once after reset |
| cfg_regs | output | 56 | Configuration bytes, byte k at bits 8k+7:8k |
| fs_sel | output | 5 | Selected frequency code |

## Verification
The bench builds the block with its defaults: 7 registers, device address 0x69, and a 2-stage synchronizer. With only 7 bytes, a write that runs past the last byte takes just a few bytes on the bus. That puts the discard path and the count byte of a read within easy reach. The 2-stage synchronizer sets how late the slave responds to each SCL edge. Because of that delay, an SCL phase of 8 system clocks is enough to check acknowledge timing and read data while keeping the run short.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int FS_W        = 5;
    localparam int SEL_SRC_BIT = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    // Power-on value of configuration byte idx in a bank of nregs bytes.
    function automatic logic [7:0] reg_default(input int idx, input int nregs);
        if (idx == 0)
            return 8'h00;
        else if (idx == nregs - 1)
            return 8'h06;
        else
            return 8'hFF;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = level_o & ~prev_q;
    assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = 7,
    parameter int IDX_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] byte_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q[g] <= reg_default(g, NUM_REGS);
            else if (wr_en && wr_idx == IDX_W'(g))
                byte_q[g] <= wr_data;
        end
        assign regs_o[g*8 +: 8] = byte_q[g];
    end
endmodule

// File: rtl/cfg_fs_select.sv
module cfg_fs_select
    import i2c_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FS_W-1:0] strap_i,
    input  logic [7:0]      ctl_byte,
    output logic [FS_W-1:0] fs_o
);
    logic            captured_q;
    logic [FS_W-1:0] strap_q;

    // Straps are sampled once, on the first edge after reset release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            captured_q <= 1'b0;
            strap_q    <= '0;
        end else if (!captured_q) begin
            captured_q <= 1'b1;
            strap_q    <= strap_i;
        end
    end

    assign fs_o = ctl_byte[SEL_SRC_BIT] ? {ctl_byte[2], ctl_byte[7:4]} : strap_q;
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = 7,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [FS_W-1:0]       strap_fs,
    output logic [NUM_REGS*8-1:0] cfg_regs,
    output logic [FS_W-1:0]       fs_sel
);
    localparam int IDX_W = $clog2(NUM_REGS + 2);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_REGS + 1);

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det, byte_done;

    bus_state_e state_q, state_d;
    logic [7:0]       shift_q, tx_byte;
    logic [3:0]       bit_q;
    logic [IDX_W-1:0] wr_idx_q, rd_idx_q;
    logic             host_nack_q;
    logic clr_bits, sample_bit, tx_load, tx_shift, wr_stb, ack_sample;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;
    assign byte_done = scl_fall && (bit_q == 4'd8);

    // Next-state and control strobes
    always_comb begin
        state_d    = state_q;
        clr_bits   = 1'b0;
        sample_bit = 1'b0;
        tx_load    = 1'b0;
        tx_shift   = 1'b0;
        wr_stb     = 1'b0;
        ack_sample = 1'b0;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d  = ST_ADDR;
            clr_bits = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    sample_bit = scl_rise;
                    if (byte_done)
                        state_d = (shift_q[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                end
                ST_CMD: begin
                    sample_bit = scl_rise;
                    if (byte_done) state_d = ST_CMD_ACK;
                end
                ST_CNT: begin
                    sample_bit = scl_rise;
                    if (byte_done) state_d = ST_CNT_ACK;
                end
                ST_WR: begin
                    sample_bit = scl_rise;
                    if (byte_done) begin
                        state_d = ST_WR_ACK;
                        wr_stb  = 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (shift_q[0]) begin
                            state_d = ST_TX;
                            tx_load = 1'b1;
                        end else begin
                            state_d  = ST_CMD;
                            clr_bits = 1'b1;
                        end
                    end
                end
                ST_CMD_ACK: if (scl_fall) begin state_d = ST_CNT; clr_bits = 1'b1; end
                ST_CNT_ACK: if (scl_fall) begin state_d = ST_WR;  clr_bits = 1'b1; end
                ST_WR_ACK:  if (scl_fall) begin state_d = ST_WR;  clr_bits = 1'b1; end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_q == 4'd7) state_d = ST_TX_ACK;
                        else               tx_shift = 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    ack_sample = scl_rise;
                    if (scl_fall) begin
                        if (host_nack_q) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_TX;
                            tx_load = 1'b1;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Read byte selection: count first, then bytes 0 upward
    always_comb begin
        tx_byte = 8'hFF;
        if (rd_idx_q == '0)
            tx_byte = 8'(NUM_REGS);
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx_q == IDX_W'(i + 1))
                tx_byte = cfg_regs[i*8 +: 8];
    end

    // Shift, bit and index datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q     <= '0;
            bit_q       <= '0;
            wr_idx_q    <= '0;
            rd_idx_q    <= '0;
            host_nack_q <= 1'b0;
        end else begin
            if (start_det) begin
                wr_idx_q <= '0;
                rd_idx_q <= '0;
            end
            if (clr_bits) bit_q <= '0;
            if (sample_bit) begin
                shift_q <= {shift_q[6:0], sda_lvl};
                bit_q   <= bit_q + 4'd1;
            end
            if (tx_load) begin
                shift_q <= tx_byte;
                bit_q   <= '0;
                if (rd_idx_q != IDX_MAX) rd_idx_q <= rd_idx_q + 1'b1;
            end
            if (tx_shift) begin
                shift_q <= {shift_q[6:0], 1'b1};
                bit_q   <= bit_q + 4'd1;
            end
            if (wr_stb && wr_idx_q != IDX_MAX) wr_idx_q <= wr_idx_q + 1'b1;
            if (ack_sample) host_nack_q <= sda_lvl;
        end
    end

    // Output process: data line pull-down
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_CNT_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_TX:                                          sda_oe = ~shift_q[7];
            default:                                        sda_oe = 1'b0;
        endcase
    end

    cfg_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_stb && (wr_idx_q < IDX_W'(NUM_REGS))),
        .wr_idx(wr_idx_q), .wr_data(shift_q), .regs_o(cfg_regs)
    );

    cfg_fs_select u_fs (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_fs),
        .ctl_byte(cfg_regs[7:0]), .fs_o(fs_sel)
    );
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] cfg_regs,
    input logic [FS_W-1:0]       fs_sel
);
    logic [NUM_REGS*8-1:0] dflt;
    logic [NUM_REGS*8-1:0] prev_q;
    logic [NUM_REGS-1:0]   byte_changed;
    logic [1:0]            age_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        assign dflt[g*8 +: 8]  = reg_default(g, NUM_REGS);
        assign byte_changed[g] = prev_q[g*8 +: 8] != cfg_regs[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= dflt;
            age_q  <= '0;
        end else begin
            prev_q <= cfg_regs;
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_regs == dflt);

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R7
    fs_from_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_regs[SEL_SRC_BIT] |-> fs_sel == {cfg_regs[2], cfg_regs[7:4]});

    // R8
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && !cfg_regs[SEL_SRC_BIT] && !$past(cfg_regs[SEL_SRC_BIT]))
            |-> $stable(fs_sel));

    // R10
    one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(byte_changed) <= 1);
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .cfg_regs(cfg_regs), .fs_sel(fs_sel)
);

// File: tb/test_i2c_cfg_slave.sv
module test_i2c_cfg_slave;
    localparam int NREG = 7;
    localparam int Q    = 8;
    localparam logic [4:0] STRAP0 = 5'b10110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_sda = 1'b1;
    logic [4:0] strap = STRAP0;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] cfg_regs;
    logic [4:0] fs_sel;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NREG];
    logic [NREG*8-1:0] prev_regs;

    assign sda_line = host_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2c_cfg_slave i_i2c_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_fs(strap), .cfg_regs(cfg_regs), .fs_sel(fs_sel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt_of(input int i);
        return (i == 0) ? 8'h00 : (i == NREG - 1) ? 8'h06 : 8'hFF;
    endfunction

    function automatic logic [4:0] exp_fs();
        return model[0][3] ? {model[0][2], model[0][7:4]} : STRAP0;
    endfunction

    // R9 monitor: data pull-down may only change while SCL is low
    always @(sda_oe) begin
        if (rst_n) begin
            checks++;
            if (scl !== 1'b0) begin
                errors++;
                $display("FAIL R9: actual scl=%0b expected scl=0 at sda_oe change", scl);
            end
        end
    end

    // R10 monitor: at most one byte changes per cycle
    always @(negedge clk) begin
        if (rst_n && prev_regs !== cfg_regs) begin
            int n;
            n = 0;
            for (int i = 0; i < NREG; i++)
                if (prev_regs[i*8 +: 8] !== cfg_regs[i*8 +: 8]) n++;
            check("R10 bytes changed in one cycle", 8'(n > 1), 8'd0);
        end
        prev_regs = cfg_regs;
    end

    task automatic wait_q;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        host_sda = 1'b1; wait_q;
        scl = 1'b1;      wait_q;
        host_sda = 1'b0; wait_q;
        scl = 1'b0;      wait_q;
    endtask

    task automatic bus_stop;
        host_sda = 1'b0; wait_q;
        scl = 1'b1;      wait_q;
        host_sda = 1'b1; wait_q; wait_q;
    endtask

    task automatic put_bit(input logic b);
        host_sda = b; wait_q;
        scl = 1'b1;   wait_q; wait_q;
        scl = 1'b0;   wait_q;
    endtask

    task automatic get_bit(output logic b);
        host_sda = 1'b1; wait_q;
        scl = 1'b1;      wait_q;
        b = sda_line;    wait_q;
        scl = 1'b0;      wait_q;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic nb;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(nb);
        ack = ~nb;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic write_regs(input int n, input logic [7:0] d [12]);
        logic a;
        bus_start;
        send_byte(8'hD2, a);                 check("R2 write address ack", 8'(a), 8'd1);
        send_byte(8'($urandom_range(255)), a); check("R3 command byte ack", 8'(a), 8'd1);
        send_byte(8'($urandom_range(255)), a); check("R3 count byte ack", 8'(a), 8'd1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a);
            if (i < NREG) begin
                check("R4 data byte ack", 8'(a), 8'd1);
                model[i] = d[i];
            end else begin
                check("R5 overflow byte ack", 8'(a), 8'd1);
            end
        end
        bus_stop;
    endtask

    task automatic compare_regs(input string req);
        for (int i = 0; i < NREG; i++)
            check(req, cfg_regs[i*8 +: 8], model[i]);
        check("R7 fs_sel", 8'(fs_sel), 8'(exp_fs()));
    endtask

    task automatic read_all;
        logic a;
        logic [7:0] v;
        bus_start;
        send_byte(8'hD3, a);
        check("R2 read address ack", 8'(a), 8'd1);
        recv_byte(v, 1'b0);
        check("R6 read count", v, 8'(NREG));
        for (int i = 0; i < NREG; i++) begin
            recv_byte(v, i == NREG - 1);
            check("R6 read data", v, model[i]);
        end
        bus_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d [12];
        void'($urandom(32'd2718));
        prev_regs = '0;
        for (int i = 0; i < NREG; i++) model[i] = dflt_of(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset values, R8 strap capture
        compare_regs("R1 reset value");
        check("R8 strap captured", 8'(fs_sel), 8'(STRAP0));
        strap = 5'b01001;
        repeat (6) @(negedge clk);
        check("R8 strap change ignored", 8'(fs_sel), 8'(STRAP0));

        // R2 foreign address is not acknowledged, slave stays idle
        bus_start;
        send_byte(8'hA0, a); check("R2 foreign address nack", 8'(a), 8'd0);
        send_byte(8'h55, a); check("R2 idle until START", 8'(a), 8'd0);
        send_byte(8'h00, a); check("R2 idle until START", 8'(a), 8'd0);
        bus_stop;
        compare_regs("R2 regs untouched");

        // R3 command and count only
        write_regs(0, d);
        compare_regs("R3 framing bytes discarded");

        // R4/R5 full write plus overflow, byte0 bit3 set
        d[0] = 8'hAC; d[1] = 8'h12; d[2] = 8'h34; d[3] = 8'h56;
        d[4] = 8'h78; d[5] = 8'h9A; d[6] = 8'hBC; d[7] = 8'hDE; d[8] = 8'hF0;
        write_regs(9, d);
        compare_regs("R4 full write");
        check("R7 fs from register", 8'(fs_sel), 8'h1A);
        read_all;

        // R4 partial write restarts at byte 0, R7 back to straps
        d[0] = 8'h00; d[1] = 8'h3C;
        write_regs(2, d);
        compare_regs("R4 partial write");
        check("R7 fs from straps", 8'(fs_sel), 8'(STRAP0));

        // Random block writes with periodic read-back
        for (int it = 0; it < 12; it++) begin
            int n;
            n = $urandom_range(10);
            for (int i = 0; i < 12; i++) d[i] = 8'($urandom_range(255));
            write_regs(n, d);
            compare_regs("R4 random write");
            if (it % 3 == 2) read_all;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule